// File: doc/BRIEF.md
# Effective Address Generation Unit

This block turns the address part of a decoded register-to-storage instruction into a 20-bit physical operand address. In immediate mode it returns the operand itself. The opcode has already been stripped by the decoder. The block receives a 23-bit address part made of a general register number, an indirection flag, a two-bit mode selector and a 16-bit displacement. It also takes the current instruction's PC, a register file read port, and dedicated base, index and segment registers.

A 16-bit offset is formed in one of four ways: straight from the displacement, PC-relative, register-relative, or indexed. The offset is then placed in the current segment, as segment times 16 plus offset, wrapped to 20 bits. When the indirection flag is set, that translated address is not the result. It is sent to a single-word memory read port, and the returned word becomes the offset that is translated. The block uses a start/busy/done handshake. A direct computation completes one cycle after start. An indirect one completes one cycle after the memory acknowledges.

Top module: `ea_gen_unit`

## Requirements
- R1: While reset is asserted and after it is released with no start, `done`, `busy`, `mem_req`, `pa_valid` and `opnd_valid` are low.
- R2: `addr_part` is laid out as bits [22:19] register number, bit [18] indirection flag, bits [17:16] mode, bits [15:0] displacement. `rf_addr` always equals bits [22:19].
- R3: Mode 00 with the flag clear gives offset = displacement. `done` and `pa_valid` are high in the cycle after `start` is sampled, and `mem_req` stays low.
- R4: Mode 01 gives offset = `pc` + displacement, modulo 2^16.
- R5: Mode 10 with register number 0 gives offset = `base_reg` + displacement. With a nonzero register number it gives offset = `rf_data` + displacement, so a zero displacement yields register-indirect addressing. Both sums are modulo 2^16.
- R6: Mode 11 gives offset = `index_reg` + displacement, modulo 2^16.
- R7: `pa` = (`seg_reg` × 16 + offset) modulo 2^20.
- R8: With the flag set, `mem_req` rises in the cycle after start and `mem_addr` carries the translated pointer address. Both hold, with `busy` high, until `mem_ack` is sampled. In the next cycle `done` and `pa_valid` are high and `pa` = segment × 16 + `mem_rdata`, modulo 2^20, using the segment sampled at start.
- R9: With `imm_sel` high at start, the flag and mode are ignored. In the next cycle `done` and `opnd_valid` are high, `opnd` equals the displacement, `pa_valid` stays low and no memory request is made.
- R10: `start` while `busy` is ignored, including in the cycle that `mem_ack` completes a request. `mem_ack` while no request is pending has no effect.
- R11: All inputs are sampled at the accepting edge. `pa` holds its value until the next completion, whatever the inputs do in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an address computation |
| addr_part | input | 23 | Register number, indirection flag, mode, displacement |
| imm_sel | input | 1 | Decoder marks an immediate operand |
| pc | input | 16 | Address of the current instruction |
| rf_addr | output | 4 | Register file read address |
| rf_data | input | 16 | Register file read data |
| base_reg | input | 16 | Base register |
| index_reg | input | 16 | Index register |
| seg_reg | input | 16 | Segment register |
| mem_req | output | 1 | Pointer read request |
| mem_addr | output | 20 | Pointer read address |
| mem_ack | input | 1 | Pointer read acknowledge, data valid |
| mem_rdata | input | 16 | Pointer word |
| busy | output | 1 | Waiting for a pointer |
| done | output | 1 | One-cycle completion pulse |
| pa_valid | output | 1 | `pa` produced by this completion |
| pa | output | 20 | Physical operand address |
| opnd_valid | output | 1 | `opnd` produced by this completion |
| opnd | output | 16 | Immediate operand |

## Verification
The clash of interest is a pointer acknowledge and a fresh `start` landing on the same edge. The bench raises `mem_ack` and `start` together, with a different direct instruction on the inputs. It expects exactly one completion, carrying the indirect result. The following cycle must show `done` low and `pa` unchanged. A second clash is a `start` pulse during the wait with a changed segment. The final address must still use the segment captured at the accepting edge.

// File: rtl/ea_pkg.sv
package ea_pkg;

  typedef enum logic [1:0] {
    AM_ABS   = 2'b00,
    AM_PCREL = 2'b01,
    AM_BASE  = 2'b10,
    AM_INDEX = 2'b11
  } amode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ea_state_e;

endpackage

// File: rtl/ea_offset_calc.sv
module ea_offset_calc
  import ea_pkg::*;
#(
  parameter int OFF_W = 16,
  parameter int RN_W  = 4
) (
  input  amode_e            mode,
  input  logic [RN_W-1:0]   rn,
  input  logic [OFF_W-1:0]  disp,
  input  logic [OFF_W-1:0]  pc,
  input  logic [OFF_W-1:0]  rf_data,
  input  logic [OFF_W-1:0]  base_reg,
  input  logic [OFF_W-1:0]  index_reg,
  output logic [OFF_W-1:0]  offset
);

  logic [OFF_W-1:0] addend;
  logic             use_gpr;

  assign use_gpr = (rn != '0);

  always_comb begin
    unique case (mode)
      AM_ABS:   addend = '0;
      AM_PCREL: addend = pc;
      AM_BASE:  addend = use_gpr ? rf_data : base_reg;
      AM_INDEX: addend = index_reg;
      default:  addend = '0;
    endcase
  end

  // Sum truncated to OFF_W bits: wraps modulo 2^OFF_W.
  assign offset = disp + addend;

endmodule

// File: rtl/ea_seg_xlate.sv
module ea_seg_xlate #(
  parameter int OFF_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = OFF_W + SEG_SHIFT
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);

  localparam int SHIFTED_W = SEG_W + SEG_SHIFT;
  localparam int SUM_W     = (SHIFTED_W > PA_W) ? SHIFTED_W : PA_W;

  logic [SUM_W-1:0] seg_part;
  logic [SUM_W-1:0] off_part;
  logic [SUM_W-1:0] total;

  generate
    if (SEG_SHIFT > 0) begin : g_shift
      assign seg_part = SUM_W'({seg, {SEG_SHIFT{1'b0}}});
    end else begin : g_flat
      assign seg_part = SUM_W'(seg);
    end
  endgenerate

  assign off_part = SUM_W'(off);
  assign total    = seg_part + off_part;
  assign pa       = total[PA_W-1:0];

endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ind,
  input  logic mem_ack,
  output logic busy,
  output logic accept,
  output logic complete,
  output logic done
);

  ea_state_e state_q, state_d;
  logic      done_d;

  assign busy     = (state_q == ST_WAIT);
  assign accept   = start && !busy;
  assign complete = busy && mem_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept && ind) state_d = ST_WAIT;
      ST_WAIT: if (mem_ack)       state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
    done_d = (accept && !ind) || complete;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      done    <= done_d;
    end
  end

  // R3, R9: a direct or immediate request completes on the next cycle
  a_r3_done_next: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !ind) |=> done);

  // R8: the wait persists until acknowledged
  a_r8_wait_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ack) |=> (busy && !done));

  // R8: acknowledge ends the wait with a completion
  a_r8_ack_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_ack) |=> (done && !busy));

  // R10: no completion without a request or a pending wait
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !done);

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit
  import ea_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int RN_W      = 4,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int PA_W      = OFF_W + SEG_SHIFT,
  parameter int AP_W      = RN_W + 1 + 2 + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AP_W-1:0]  addr_part,
  input  logic             imm_sel,
  input  logic [OFF_W-1:0] pc,
  output logic [RN_W-1:0]  rf_addr,
  input  logic [OFF_W-1:0] rf_data,
  input  logic [OFF_W-1:0] base_reg,
  input  logic [OFF_W-1:0] index_reg,
  input  logic [SEG_W-1:0] seg_reg,
  output logic             mem_req,
  output logic [PA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [OFF_W-1:0] mem_rdata,
  output logic             busy,
  output logic             done,
  output logic             pa_valid,
  output logic [PA_W-1:0]  pa,
  output logic             opnd_valid,
  output logic [OFF_W-1:0] opnd
);

  localparam int MODE_LSB = OFF_W;
  localparam int IND_BIT  = OFF_W + 2;
  localparam int RN_LSB   = OFF_W + 3;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // field extraction
  logic [OFF_W-1:0] disp;
  amode_e           mode;
  logic             ind_flag;
  logic             ind;

  assign disp     = addr_part[OFF_W-1:0];
  assign mode     = amode_e'(addr_part[MODE_LSB+1:MODE_LSB]);
  assign ind_flag = addr_part[IND_BIT];
  assign rf_addr  = addr_part[RN_LSB+RN_W-1:RN_LSB];
  assign ind      = ind_flag && !imm_sel;

  // control
  logic accept, complete;

  ea_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .ind      (ind),
    .mem_ack  (mem_ack),
    .busy     (busy),
    .accept   (accept),
    .complete (complete),
    .done     (done)
  );

  assign mem_req = busy;

  // offset and translation
  logic [OFF_W-1:0] off_now;
  logic [PA_W-1:0]  pa_now;
  logic [PA_W-1:0]  pa_ptr;
  logic [SEG_W-1:0] seg_q, seg_d;

  ea_offset_calc #(.OFF_W(OFF_W), .RN_W(RN_W)) u_off (
    .mode      (mode),
    .rn        (rf_addr),
    .disp      (disp),
    .pc        (pc),
    .rf_data   (rf_data),
    .base_reg  (base_reg),
    .index_reg (index_reg),
    .offset    (off_now)
  );

  ea_seg_xlate #(.OFF_W(OFF_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_xl_now (
    .seg (seg_reg),
    .off (off_now),
    .pa  (pa_now)
  );

  ea_seg_xlate #(.OFF_W(OFF_W), .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .PA_W(PA_W)) u_xl_ptr (
    .seg (seg_q),
    .off (mem_rdata),
    .pa  (pa_ptr)
  );

  // next-state of the datapath registers
  logic             load_direct, load_imm, load_ptr;
  logic [PA_W-1:0]  mem_addr_d, pa_d;
  logic [OFF_W-1:0] opnd_d;
  logic             pa_valid_d, opnd_valid_d;

  assign load_direct = accept && !ind && !imm_sel;
  assign load_imm    = accept && imm_sel;
  assign load_ptr    = accept && ind;

  always_comb begin
    seg_d        = seg_q;
    mem_addr_d   = mem_addr;
    pa_d         = pa;
    opnd_d       = opnd;
    pa_valid_d   = load_direct || complete;
    opnd_valid_d = load_imm;
    if (accept)      seg_d      = seg_reg;
    if (load_ptr)    mem_addr_d = pa_now;
    if (load_direct) pa_d       = pa_now;
    if (complete)    pa_d       = pa_ptr;
    if (load_imm)    opnd_d     = disp;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seg_q      <= '0;
      mem_addr   <= '0;
      pa         <= '0;
      opnd       <= '0;
      pa_valid   <= 1'b0;
      opnd_valid <= 1'b0;
    end else begin
      seg_q      <= seg_d;
      mem_addr   <= mem_addr_d;
      pa         <= pa_d;
      opnd       <= opnd_d;
      pa_valid   <= pa_valid_d;
      opnd_valid <= opnd_valid_d;
    end
  end

  // R9: an address and an operand never complete together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(pa_valid && opnd_valid));

  // R9: immediate requests never reach memory
  a_r9_no_mem: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (start && !busy && imm_sel) |=> !mem_req);

  // R8: pointer address is held for the whole request
  a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mem_req && $past(mem_req)) |-> $stable(mem_addr));

  // R11: the result only moves when a completion is reported
  a_r11_pa_held: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pa_valid |-> $stable(pa));

endmodule

// File: tb/ea_gen_unit_test.sv
module ea_gen_unit_test;

  typedef struct packed {
    logic [3:0]  rn;
    logic        ind;
    logic [1:0]  x;
    logic [15:0] d;
    logic        imm;
    logic [15:0] pc;
    logic [15:0] rf;
    logic [15:0] base;
    logic [15:0] idx;
    logic [15:0] seg;
    logic [19:0] exp;
  } vec_t;

  // exp is the expected pa, or the expected operand for immediate rows
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R3 absolute
    '{4'h0, 1'b0, 2'b00, 16'h1234, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h1000, 20'h11234},
    // R4 pc-relative
    '{4'h0, 1'b0, 2'b01, 16'h0020, 1'b0, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 20'h00120},
    // R4 pc-relative wrap
    '{4'h0, 1'b0, 2'b01, 16'h0020, 1'b0, 16'hFFF0, 16'h0000, 16'h0000, 16'h0000, 16'h0001, 20'h00020},
    // R5 base register
    '{4'h0, 1'b0, 2'b10, 16'h0010, 1'b0, 16'h0000, 16'h7777, 16'h4000, 16'h0000, 16'h2000, 20'h24010},
    // R5 register-indirect through Ri
    '{4'h5, 1'b0, 2'b10, 16'h0000, 1'b0, 16'h0000, 16'h0300, 16'h9999, 16'h0000, 16'h0000, 20'h00300},
    // R6 indexed
    '{4'h0, 1'b0, 2'b11, 16'h1000, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0005, 16'h0010, 20'h01105},
    // R7 segment wrap
    '{4'h0, 1'b0, 2'b00, 16'h0020, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 20'h00010},
    // R9 immediate, flag and mode ignored
    '{4'h3, 1'b1, 2'b01, 16'hBEEF, 1'b1, 16'h1111, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 20'h0BEEF},
    // R6 indexed wrap
    '{4'h0, 1'b0, 2'b11, 16'h0002, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'h0100, 20'h01001}
  };

  logic        clk, rst_n, start, imm_sel, mem_ack;
  logic [22:0] addr_part;
  logic [15:0] pc, rf_data, base_reg, index_reg, seg_reg, mem_rdata;
  logic [3:0]  rf_addr;
  logic        mem_req, busy, done, pa_valid, opnd_valid;
  logic [19:0] mem_addr, pa;
  logic [15:0] opnd;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  ea_gen_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_part(addr_part),
    .imm_sel(imm_sel), .pc(pc), .rf_addr(rf_addr), .rf_data(rf_data),
    .base_reg(base_reg), .index_reg(index_reg), .seg_reg(seg_reg),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .pa_valid(pa_valid),
    .pa(pa), .opnd_valid(opnd_valid), .opnd(opnd)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input vec_t v);
    if (v.imm) return "R9 immediate";
    case (v.x)
      2'b00:   return "R3 absolute";
      2'b01:   return "R4 pc-relative";
      2'b10:   return "R5 base/register";
      default: return "R6 indexed";
    endcase
  endfunction

  task automatic idle_inputs();
    start = 1'b0; imm_sel = 1'b0; mem_ack = 1'b0; addr_part = '0;
    pc = '0; rf_data = '0; base_reg = '0; index_reg = '0; seg_reg = '0; mem_rdata = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!done && !busy && !mem_req && !pa_valid && !opnd_valid, "R1 in reset",
        {27'b0, done, busy, mem_req, pa_valid, opnd_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!done && !busy && !mem_req && !pa_valid && !opnd_valid, "R1 after release",
        {27'b0, done, busy, mem_req, pa_valid, opnd_valid}, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      addr_part = {v.rn, v.ind, v.x, v.d};
      imm_sel = v.imm; pc = v.pc; rf_data = v.rf; base_reg = v.base;
      index_reg = v.idx; seg_reg = v.seg; start = 1'b1;
      #1;
      chk(rf_addr == v.rn, "R2 rf_addr", 32'(rf_addr), 32'(v.rn));
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b1, {tag_of(v), " done"}, 32'(done), 1);
      chk(mem_req == 1'b0, {tag_of(v), " no mem_req"}, 32'(mem_req), 0);
      if (v.imm) begin
        chk(opnd_valid && !pa_valid, "R9 valid flags", {30'b0, opnd_valid, pa_valid}, 2);
        chk(opnd == v.d, "R9 operand", 32'(opnd), 32'(v.d));
      end else begin
        chk(pa_valid && !opnd_valid, {tag_of(v), " valid flags"}, {30'b0, pa_valid, opnd_valid}, 2);
        chk(pa == v.exp, {tag_of(v), " R7 pa"}, 32'(pa), 32'(v.exp));
      end
    end

    // R11: inputs changing after acceptance do not move pa
    @(negedge clk);
    addr_part = {4'h0, 1'b0, 2'b00, 16'h0001}; imm_sel = 1'b0; seg_reg = 16'h0001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(pa == 20'h00011, "R11 pa", 32'(pa), 32'h11);
    seg_reg = 16'hFFFF; addr_part = {4'h0, 1'b0, 2'b00, 16'hAAAA};
    @(negedge clk);
    chk(pa == 20'h00011 && !done, "R11 pa held", 32'(pa), 32'h11);

    // R10: acknowledge while idle
    mem_ack = 1'b1; mem_rdata = 16'h5555;
    @(negedge clk);
    mem_ack = 1'b0;
    @(negedge clk);
    chk(!done && !pa_valid, "R10 stray ack", {30'b0, done, pa_valid}, 0);

    // R8: memory-indirect, slow acknowledge, with a start during the wait
    addr_part = {4'h0, 1'b1, 2'b00, 16'h0040}; seg_reg = 16'h0100; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_req && busy && !done, "R8 request raised", {29'b0, mem_req, busy, done}, 6);
    chk(mem_addr == 20'h01040, "R8 pointer address", 32'(mem_addr), 32'h01040);
    seg_reg = 16'h0000; addr_part = {4'h0, 1'b0, 2'b00, 16'h0777}; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_req && !done, "R10 start while busy", {30'b0, mem_req, done}, 2);
    @(negedge clk);
    chk(mem_req && mem_addr == 20'h01040, "R8 request held", 32'(mem_addr), 32'h01040);
    // ack and a new start on the same edge
    mem_ack = 1'b1; mem_rdata = 16'h2222; start = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0; start = 1'b0;
    chk(done && pa_valid, "R8 completion", {30'b0, done, pa_valid}, 3);
    chk(pa == 20'h03222, "R8 pointer pa", 32'(pa), 32'h03222);
    chk(!mem_req && !busy, "R8 request dropped", {30'b0, mem_req, busy}, 0);
    @(negedge clk);
    chk(!done && pa == 20'h03222, "R10 start at ack ignored", 32'(pa), 32'h03222);

    // R8: PC-relative pointer, acknowledge on the first cycle
    addr_part = {4'h0, 1'b1, 2'b01, 16'h0004}; pc = 16'h0010; seg_reg = 16'h0000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_addr == 20'h00014 && mem_req, "R8 pc-rel pointer", 32'(mem_addr), 32'h00014);
    mem_ack = 1'b1; mem_rdata = 16'hFFFF;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(done && pa == 20'h0FFFF, "R8 fast ack pa", 32'(pa), 32'h0FFFF);

    @(negedge clk);
    finish_run();
  end

endmodule